// File: doc/BRIEF.md
# Privileged Control Register Bank with Write Legalization

This block is the 64-bit control and status register bank of a small hart. The core reads and writes registers by index. The block keeps the current privilege level, counts clock cycles and retired instructions, and applies a legalizing filter to every write. The filter can keep a field fixed, refuse an illegal encoding, offset a stored value, or accept a bit change only when a condition on the incoming next-PC holds.

Reads are combinational and appear in the same cycle as the request. A write takes effect at the clock edge and can be read back from the following cycle. A read of a counter that the active privilege may not see returns zero and raises a fault for that cycle. An index beyond the implemented range also raises a fault, on a read and on a write. Trap entry, address translation, memory protection and interrupt registers are handled elsewhere.

Index map: 0 privilege, 1 ISA, 2 to 5 identity, 6 status, 7 machine counter enable, 8 supervisor counter enable, 9 trigger select, 10 machine exception PC, 11 supervisor exception PC, 12 translation control, 13 to 31 plain scratch, and 32 to 63 the counters. Counter offset 0 is cycles, 1 is time, 2 is retired instructions, and 3 to 31 are the event counters.

Top module: `csr_bank`

## Requirements
- R1: While reset is held and directly after it, the registers read as follows. Privilege reads 3. ISA reads 0x8000_0000_0014_112D. Status reads 0x0000_000A_0000_0000. Index 7 and index 8 read 7. Index 9 reads 1. Every other register, and both counters, reads 0.
- R2: Counter indices 32+k (k from 0 to 31) are gated by the stored privilege. Privilege 3 may read all of them. Privilege 1 may read counter k only when bit k of index 7 is set. Privilege 0 may read it only when bit k of index 8 is set. A denied read returns 0, and rd_fault is 1 in that cycle.
- R3: Indices 32, 33 and 35 to 63 read the number of clock edges since reset was released. Index 34 reads the number of edges at which retire was 1.
- R4: A write to an index from 32 to 63 has no effect on any counter and raises no fault.
- R5: A read of index 10 or 11 always returns bit 0 as 0. When ISA bit 2 is 0, bit 1 also reads 0. The stored value keeps both bits.
- R6: A write to index 12 updates bits 63:60 only when the new value there is 0 or 8. Otherwise those bits keep their previous value. Bits 59:0 always update.
- R7: Writing v to index 9 stores v+1 modulo 2^64.
- R8: A write to index 1 that clears bit 2 clears it only when next_pc[2:0] is 0. Otherwise bit 2 keeps its old value. All other bits take the written value.
- R9: Bits 35:32 of status (index 6) stay at 0xA across every write. The other bits take the written value.
- R10: A read with index 64 or above returns 0 with rd_fault 1. A write with index 64 or above raises wr_fault in its cycle and changes no register.
- R11: A write to index 0 keeps only bits 1:0. The value 2 is refused and the old privilege is kept.
- R12: Indices 2 to 5 and 13 to 31 store the written value unchanged. It is readable from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read request |
| rd_idx | input | IDX_W | Read register index |
| rd_data | output | 64 | Read value (combinational), 0 when denied |
| rd_fault | output | 1 | Denied counter or out-of-range read |
| wr_en | input | 1 | Write request |
| wr_idx | input | IDX_W | Write register index |
| wr_data | input | 64 | Write value before legalization |
| next_pc | input | 64 | PC of the following instruction, used by the ISA filter |
| wr_fault | output | 1 | Out-of-range write |
| retire | input | 1 | One instruction retires at this edge |

## Verification
Two functions can fall in the same cycle. One is the ISA write whose compressed bit decides the exception-PC read mask. The other is the exception-PC read itself. The bench stores exception PCs with both low bits set. It then clears the compressed bit under aligned and misaligned next-PC values, and reads the PCs back, expecting bit 1 to vanish only after an accepted clear and to return once the bit is set again. In the same way, the gating sweep rewrites the privilege and both enable masks, giving the two masks complementary values so that selecting the wrong mask shows up. It then compares every counter read against the bench's own edge and retire counts.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

   localparam int XLEN = 64;

   typedef enum logic [1:0] {
      LVL_USER = 2'd0,
      LVL_SUPV = 2'd1,
      LVL_RSVD = 2'd2,
      LVL_MACH = 2'd3
   } lvl_e;

   localparam int IX_PRIV   = 0;
   localparam int IX_ISA    = 1;
   localparam int IX_STATUS = 6;
   localparam int IX_MCEN   = 7;
   localparam int IX_SCEN   = 8;
   localparam int IX_TSEL   = 9;
   localparam int IX_MEPC   = 10;
   localparam int IX_SEPC   = 11;
   localparam int IX_XLAT   = 12;
   localparam int IX_LAST_FIXED = 12;

   localparam int CNT_SPAN  = 32;
   localparam int CNT_OFF_RET = 2;

   localparam int ISA_CBIT  = 2;
   localparam logic [63:0] ISA_RESET = (64'd2 << 62) | 64'h0014_112D;

   localparam int XL_LSB    = 32;
   localparam logic [3:0] XL_FIXED = 4'hA;
   localparam logic [63:0] STATUS_RESET = {28'd0, XL_FIXED, 32'd0};

   localparam int MODE_LSB  = 60;
   localparam logic [3:0] MODE_BARE = 4'd0;
   localparam logic [3:0] MODE_SV39 = 4'd8;

   localparam logic [63:0] CEN_RESET  = 64'h7;
   localparam logic [63:0] TSEL_RESET = 64'h1;

   function automatic logic [63:0] slot_reset(input int i);
      logic [63:0] v;
      case (i)
         IX_PRIV:   v = {62'd0, LVL_MACH};
         IX_ISA:    v = ISA_RESET;
         IX_STATUS: v = STATUS_RESET;
         IX_MCEN:   v = CEN_RESET;
         IX_SCEN:   v = CEN_RESET;
         IX_TSEL:   v = TSEL_RESET;
         default:   v = 64'd0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/csr_wr_filter.sv
module csr_wr_filter
   import csr_bank_pkg::*;
#(
   parameter int SW = 5
) (
   input  logic [SW-1:0] slot,
   input  logic [63:0]   wdata,
   input  logic [63:0]   old,
   input  logic [63:0]   next_pc,
   output logic [63:0]   legal
);

   localparam logic [SW-1:0] K_PRIV   = SW'(IX_PRIV);
   localparam logic [SW-1:0] K_ISA    = SW'(IX_ISA);
   localparam logic [SW-1:0] K_STATUS = SW'(IX_STATUS);
   localparam logic [SW-1:0] K_TSEL   = SW'(IX_TSEL);
   localparam logic [SW-1:0] K_XLAT   = SW'(IX_XLAT);

   logic [3:0] new_mode;
   logic       mode_ok;
   logic       c_clear_blocked;
   logic       lvl_bad;

   assign new_mode        = wdata[MODE_LSB +: 4];
   assign mode_ok         = (new_mode == MODE_BARE) || (new_mode == MODE_SV39);
   assign c_clear_blocked = !wdata[ISA_CBIT] && (next_pc[2:0] != 3'd0);
   assign lvl_bad         = (wdata[1:0] == LVL_RSVD);

   always_comb begin
      legal = wdata;
      if (slot == K_PRIV) begin
         legal = {62'd0, lvl_bad ? old[1:0] : wdata[1:0]};
      end else if (slot == K_ISA) begin
         if (c_clear_blocked) legal[ISA_CBIT] = old[ISA_CBIT];
      end else if (slot == K_STATUS) begin
         legal[XL_LSB +: 4] = old[XL_LSB +: 4];
      end else if (slot == K_TSEL) begin
         legal = wdata + 64'd1;
      end else if (slot == K_XLAT) begin
         if (!mode_ok) legal[MODE_LSB +: 4] = old[MODE_LSB +: 4];
      end
   end

endmodule

// File: rtl/csr_counters.sv
module csr_counters #(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             retire,
   output logic [CNT_W-1:0] cyc,
   output logic [CNT_W-1:0] ret
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc <= '0;
         ret <= '0;
      end else begin
         cyc <= cyc + CNT_W'(1);
         if (retire) ret <= ret + CNT_W'(1);
      end
   end

endmodule

// File: rtl/csr_rd_path.sv
module csr_rd_path
   import csr_bank_pkg::*;
#(
   parameter int IDX_W    = 7,
   parameter int CNT_BASE = 32,
   parameter int CNT_W    = 64
) (
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [63:0]      slot_val,
   input  logic [1:0]       lvl,
   input  logic [31:0]      mcen,
   input  logic [31:0]      scen,
   input  logic             isa_c,
   input  logic [CNT_W-1:0] cyc,
   input  logic [CNT_W-1:0] ret,
   output logic [63:0]      rd_data,
   output logic             rd_fault
);

   localparam int NUM_IDX = CNT_BASE + CNT_SPAN;
   localparam logic [IDX_W:0]   LIMIT = (IDX_W+1)'(NUM_IDX);
   localparam logic [IDX_W-1:0] CBASE = IDX_W'(CNT_BASE);
   localparam logic [IDX_W-1:0] K_MEPC = IDX_W'(IX_MEPC);
   localparam logic [IDX_W-1:0] K_SEPC = IDX_W'(IX_SEPC);

   logic [63:0]      cyc_x, ret_x;
   logic             in_range, is_cnt, allowed;
   logic [IDX_W-1:0] rel;
   logic [4:0]       off;
   logic [63:0]      val;

   generate
      if (CNT_W == XLEN) begin : g_full
         assign cyc_x = cyc;
         assign ret_x = ret;
      end else begin : g_pad
         assign cyc_x = {{(XLEN-CNT_W){1'b0}}, cyc};
         assign ret_x = {{(XLEN-CNT_W){1'b0}}, ret};
      end
   endgenerate

   assign in_range = ({1'b0, rd_idx} < LIMIT);
   assign is_cnt   = in_range && (rd_idx >= CBASE);
   assign rel      = rd_idx - CBASE;
   assign off      = rel[4:0];

   always_comb begin
      case (lvl)
         LVL_MACH: allowed = 1'b1;
         LVL_SUPV: allowed = mcen[off];
         LVL_USER: allowed = scen[off];
         default:  allowed = 1'b0;
      endcase
   end

   always_comb begin
      if (is_cnt) begin
         val = (off == 5'(CNT_OFF_RET)) ? ret_x : cyc_x;
      end else begin
         val = slot_val;
         if (rd_idx == K_MEPC || rd_idx == K_SEPC) begin
            val[0] = 1'b0;
            if (!isa_c) val[1] = 1'b0;
         end
      end
   end

   assign rd_fault = rd_en && (!in_range || (is_cnt && !allowed));
   assign rd_data  = (rd_en && !rd_fault) ? val : 64'd0;

endmodule

// File: rtl/csr_bank.sv
module csr_bank
   import csr_bank_pkg::*;
#(
   parameter int IDX_W    = 7,
   parameter int CNT_BASE = 32,
   parameter int CNT_W    = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [63:0]      rd_data,
   output logic             rd_fault,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [63:0]      wr_data,
   input  logic [63:0]      next_pc,
   output logic             wr_fault,
   input  logic             retire
);

   localparam int SW      = $clog2(CNT_BASE);
   localparam int NUM_IDX = CNT_BASE + CNT_SPAN;
   localparam logic [IDX_W:0]   LIMIT = (IDX_W+1)'(NUM_IDX);
   localparam logic [IDX_W-1:0] CBASE = IDX_W'(CNT_BASE);

   generate
      if ((1 << SW) != CNT_BASE) begin : g_bad_base
         $error("CNT_BASE must be a power of two");
      end
      if (CNT_BASE <= IX_LAST_FIXED) begin : g_small_base
         $error("CNT_BASE must exceed the fixed register indices");
      end
      if (NUM_IDX > (1 << IDX_W)) begin : g_bad_idx
         $error("IDX_W too narrow for the counter range");
      end
      if (CNT_W < 1 || CNT_W > XLEN) begin : g_bad_cnt
         $error("CNT_W must lie in 1..64");
      end
   endgenerate

   logic [63:0]   slot_val [CNT_BASE];
   logic [SW-1:0] wr_slot;
   logic          wr_store;
   logic [63:0]   wr_old;
   logic [63:0]   wr_legal;

   assign wr_slot  = wr_idx[SW-1:0];
   assign wr_store = wr_en && (wr_idx < CBASE);
   assign wr_old   = slot_val[wr_slot];
   assign wr_fault = wr_en && !({1'b0, wr_idx} < LIMIT);

   csr_wr_filter #(.SW(SW)) u_filt (
      .slot    (wr_slot),
      .wdata   (wr_data),
      .old     (wr_old),
      .next_pc (next_pc),
      .legal   (wr_legal)
   );

   generate
      for (genvar i = 0; i < CNT_BASE; i++) begin : g_slot
         logic [63:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= slot_reset(i);
            end else if (wr_store && (wr_slot == SW'(i))) begin
               q <= wr_legal;
            end
         end
         assign slot_val[i] = q;
      end
   endgenerate

   logic [1:0]  priv_q;
   logic [63:0] isa_q, status_q, xlat_q, tsel_q;
   logic [31:0] mcen_q, scen_q;

   assign priv_q   = slot_val[IX_PRIV][1:0];
   assign isa_q    = slot_val[IX_ISA];
   assign status_q = slot_val[IX_STATUS];
   assign xlat_q   = slot_val[IX_XLAT];
   assign tsel_q   = slot_val[IX_TSEL];
   assign mcen_q   = slot_val[IX_MCEN][31:0];
   assign scen_q   = slot_val[IX_SCEN][31:0];

   logic [CNT_W-1:0] cyc, ret;

   csr_counters #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .retire (retire),
      .cyc    (cyc),
      .ret    (ret)
   );

   csr_rd_path #(.IDX_W(IDX_W), .CNT_BASE(CNT_BASE), .CNT_W(CNT_W)) u_rd (
      .rd_en    (rd_en),
      .rd_idx   (rd_idx),
      .slot_val (slot_val[rd_idx[SW-1:0]]),
      .lvl      (priv_q),
      .mcen     (mcen_q),
      .scen     (scen_q),
      .isa_c    (isa_q[ISA_CBIT]),
      .cyc      (cyc),
      .ret      (ret),
      .rd_data  (rd_data),
      .rd_fault (rd_fault)
   );

endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk
   import csr_bank_pkg::*;
#(
   parameter int IDX_W    = 7,
   parameter int CNT_BASE = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_en,
   input logic [IDX_W-1:0] rd_idx,
   input logic [63:0]      rd_data,
   input logic             rd_fault,
   input logic             wr_en,
   input logic [IDX_W-1:0] wr_idx,
   input logic [63:0]      wr_data,
   input logic [63:0]      next_pc,
   input logic             wr_fault,
   input logic [1:0]       priv_q,
   input logic [63:0]      isa_q,
   input logic [63:0]      status_q,
   input logic [63:0]      xlat_q,
   input logic [63:0]      tsel_q
);

   localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(CNT_BASE + CNT_SPAN);

   // R7
   tsel_skew_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(IX_TSEL)) |=> (tsel_q == $past(wr_data) + 64'd1));

   // R6
   xlat_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(IX_XLAT) &&
       wr_data[63:60] != MODE_BARE && wr_data[63:60] != MODE_SV39)
      |=> (xlat_q[63:60] == $past(xlat_q[63:60])));

   // R8
   isa_c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(IX_ISA) && !wr_data[ISA_CBIT] && next_pc[2:0] != 3'd0)
      |=> (isa_q[ISA_CBIT] == $past(isa_q[ISA_CBIT])));

   // R9
   status_xl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(IX_STATUS)) |=> (status_q[35:32] == XL_FIXED));

   // R11
   priv_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == IDX_W'(IX_PRIV) && wr_data[1:0] == LVL_RSVD)
      |=> $stable(priv_q));

   // R10
   oor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !({1'b0, rd_idx} < LIMIT)) |-> (rd_fault && rd_data == 64'd0));

   // R10
   oor_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !({1'b0, wr_idx} < LIMIT)) |-> wr_fault);

   // R5
   epc_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (rd_idx == IDX_W'(IX_MEPC) || rd_idx == IDX_W'(IX_SEPC))) |-> !rd_data[0]);

endmodule

bind csr_bank csr_bank_chk #(.IDX_W(IDX_W), .CNT_BASE(CNT_BASE)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_en    (rd_en),
   .rd_idx   (rd_idx),
   .rd_data  (rd_data),
   .rd_fault (rd_fault),
   .wr_en    (wr_en),
   .wr_idx   (wr_idx),
   .wr_data  (wr_data),
   .next_pc  (next_pc),
   .wr_fault (wr_fault),
   .priv_q   (priv_q),
   .isa_q    (isa_q),
   .status_q (status_q),
   .xlat_q   (xlat_q),
   .tsel_q   (tsel_q)
);

// File: tb/sim_csr_bank.sv
module sim_csr_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en = 1'b0;
   logic [6:0]  rd_idx = '0;
   logic [63:0] rd_data;
   logic        rd_fault;
   logic        wr_en = 1'b0;
   logic [6:0]  wr_idx = '0;
   logic [63:0] wr_data = '0;
   logic [63:0] next_pc = '0;
   logic        wr_fault;
   logic        retire = 1'b0;

   int checks = 0;
   int fails  = 0;
   logic [63:0] tb_cyc = 0;
   logic [63:0] tb_ret = 0;

   always #4 clk = ~clk;

   csr_bank u0 (
      .clk(clk), .rst_n(rst_n),
      .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .rd_fault(rd_fault),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .next_pc(next_pc),
      .wr_fault(wr_fault), .retire(retire)
   );

   always @(posedge clk) begin
      if (rst_n) begin
         tb_cyc <= tb_cyc + 64'd1;
         if (retire) tb_ret <= tb_ret + 64'd1;
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         retire = (tb_cyc % 3 != 0);
      end
   end

   localparam logic [63:0] ISA_RST = 64'h8000_0000_0014_112D;
   localparam logic [63:0] ST_RST  = 64'h0000_000A_0000_0000;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_rd(input logic [6:0] idx, output logic [63:0] d, output logic f);
      @(negedge clk);
      rd_en = 1'b1;
      rd_idx = idx;
      #1;
      d = rd_data;
      f = rd_fault;
      rd_en = 1'b0;
   endtask

   task automatic do_wr(input logic [6:0] idx, input logic [63:0] d,
                        input logic [63:0] npc, output logic f);
      @(negedge clk);
      wr_en = 1'b1;
      wr_idx = idx;
      wr_data = d;
      next_pc = npc;
      #1;
      f = wr_fault;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [6:0] idx,
                         input logic [63:0] exp, input logic expf);
      logic [63:0] d;
      logic f;
      do_rd(idx, d, f);
      check(tag, d, exp);
      check(tag, {63'd0, f}, {63'd0, expf});
   endtask

   task automatic wr_q(input logic [6:0] idx, input logic [63:0] d, input logic [63:0] npc);
      logic f;
      do_wr(idx, d, npc, f);
      check("R10 in-range write no fault", {63'd0, f}, 64'd0);
   endtask

   initial begin
      logic [63:0] d, v, exp, prev;
      logic f;
      logic [1:0] lvl;
      logic [31:0] masks [4];
      masks[0] = 32'h0000_0000; masks[1] = 32'hFFFF_FFFF;
      masks[2] = 32'h5555_AAAA; masks[3] = 32'h8000_0001;

      // R1 reset state while reset is held
      repeat (2) @(negedge clk);
      rd_chk("R1 priv", 7'd0, 64'd3, 1'b0);
      rd_chk("R1 isa", 7'd1, ISA_RST, 1'b0);
      rd_chk("R1 status", 7'd6, ST_RST, 1'b0);
      rd_chk("R1 mcen", 7'd7, 64'd7, 1'b0);
      rd_chk("R1 scen", 7'd8, 64'd7, 1'b0);
      rd_chk("R1 tsel", 7'd9, 64'd1, 1'b0);
      rd_chk("R1 xlat", 7'd12, 64'd0, 1'b0);
      rd_chk("R1 mepc", 7'd10, 64'd0, 1'b0);
      rd_chk("R1 id", 7'd5, 64'd0, 1'b0);
      rd_chk("R1 scratch", 7'd20, 64'd0, 1'b0);
      rd_chk("R1 cycle", 7'd32, 64'd0, 1'b0);
      rd_chk("R1 instret", 7'd34, 64'd0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      // R12 plain storage
      for (int i = 2; i < 32; i++) begin
         if (i >= 6 && i <= 12) continue;
         wr_q(7'(i), {32'hA5C3_0000 | 32'(i), ~32'(i * 7)}, 64'd0);
      end
      for (int i = 2; i < 32; i++) begin
         if (i >= 6 && i <= 12) continue;
         rd_chk("R12 plain readback", 7'(i), {32'hA5C3_0000 | 32'(i), ~32'(i * 7)}, 1'b0);
      end

      // R3 counter values in machine mode
      repeat (5) @(negedge clk);
      for (int k = 0; k < 32; k++) begin
         do_rd(7'(32 + k), d, f);
         exp = (k == 2) ? tb_ret : tb_cyc;
         check("R3 counter value", d, exp);
      end

      // R2 gating by privilege and complementary masks
      for (int p = 0; p < 2; p++) begin
         for (int m = 0; m < 4; m++) begin
            wr_q(7'd7, {32'd0, masks[m]}, 64'd0);
            wr_q(7'd8, {32'd0, ~masks[m]}, 64'd0);
            wr_q(7'd0, 64'(p), 64'd0);
            for (int k = 0; k < 32; k++) begin
               logic en;
               do_rd(7'(32 + k), d, f);
               en = (p == 1) ? masks[m][k] : ~masks[m][k];
               exp = en ? ((k == 2) ? tb_ret : tb_cyc) : 64'd0;
               check("R2 gated data", d, exp);
               check("R2 gated fault", {63'd0, f}, {63'd0, ~en});
            end
            wr_q(7'd0, 64'd3, 64'd0);
         end
      end
      wr_q(7'd7, 64'd0, 64'd0);
      wr_q(7'd8, 64'd0, 64'd0);
      for (int k = 0; k < 32; k++) begin
         do_rd(7'(32 + k), d, f);
         check("R2 machine ignores masks", {63'd0, f}, 64'd0);
      end

      // R11 privilege legalization
      prev = 64'd3;
      for (int s = 0; s < 8; s++) begin
         lvl = 2'(s ^ 1);
         wr_q(7'd0, 64'hFFFF_FFFF_FFFF_FFF0 | 64'(lvl), 64'd0);
         if (lvl != 2'd2) prev = 64'(lvl);
         rd_chk("R11 priv", 7'd0, prev, 1'b0);
      end
      wr_q(7'd0, 64'd3, 64'd0);

      // R4 counter writes ignored
      for (int k = 0; k < 32; k++) begin
         do_wr(7'(32 + k), 64'h0, 64'd0, f);
         check("R4 counter write no fault", {63'd0, f}, 64'd0);
      end
      do_rd(7'd32, d, f);
      check("R4 cycle unchanged", d, tb_cyc);
      do_rd(7'd34, d, f);
      check("R4 instret unchanged", d, tb_ret);

      // R5 exception PC read mask, with the ISA C bit toggled
      for (int lo = 0; lo < 4; lo++) begin
         v = 64'h1234_5678_9ABC_DEF0 | 64'(lo);
         wr_q(7'd1, ISA_RST, 64'd0);
         wr_q(7'd10, v, 64'd0);
         wr_q(7'd11, ~v ^ 64'd3 ^ 64'(lo), 64'd0);
         rd_chk("R5 mepc C set", 7'd10, v & ~64'd1, 1'b0);
         rd_chk("R5 sepc C set", 7'd11, (~v ^ 64'd3 ^ 64'(lo)) & ~64'd1, 1'b0);
         wr_q(7'd1, ISA_RST & ~64'd4, 64'd0);
         rd_chk("R5 mepc C clear", 7'd10, v & ~64'd3, 1'b0);
         rd_chk("R5 sepc C clear", 7'd11, (~v ^ 64'd3 ^ 64'(lo)) & ~64'd3, 1'b0);
      end
      wr_q(7'd1, ISA_RST, 64'd0);
      rd_chk("R5 mepc restored", 7'd10, (64'h1234_5678_9ABC_DEF0 | 64'd3) & ~64'd1, 1'b0);

      // R8 clearing C depends on next_pc alignment
      for (int n = 0; n < 8; n++) begin
         wr_q(7'd1, ISA_RST, 64'd0);
         v = (ISA_RST ^ 64'h1000) & ~64'd4;
         wr_q(7'd1, v, 64'h8000_0000 | 64'(n));
         exp = (n == 0) ? v : (v | 64'd4);
         rd_chk("R8 isa C clear", 7'd1, exp, 1'b0);
      end
      wr_q(7'd1, ISA_RST, 64'd0);

      // R6 translation mode filter
      prev = 64'd0;
      for (int m = 0; m < 16; m++) begin
         v = {4'(m), 60'h0AB_CDEF_0123_4560 ^ 60'(m)};
         wr_q(7'd12, v, 64'd0);
         if (m == 0 || m == 8) prev = 64'(m);
         exp = {prev[3:0], v[59:0]};
         rd_chk("R6 xlat mode", 7'd12, exp, 1'b0);
      end

      // R7 trigger select skew
      wr_q(7'd9, 64'd0, 64'd0);
      rd_chk("R7 tsel zero", 7'd9, 64'd1, 1'b0);
      wr_q(7'd9, 64'd5, 64'd0);
      rd_chk("R7 tsel five", 7'd9, 64'd6, 1'b0);
      wr_q(7'd9, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
      rd_chk("R7 tsel wrap", 7'd9, 64'd0, 1'b0);
      wr_q(7'd9, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0);
      rd_chk("R7 tsel carry", 7'd9, 64'h8000_0000_0000_0000, 1'b0);

      // R9 status width fields fixed
      for (int s = 0; s < 3; s++) begin
         v = (s == 0) ? 64'd0 : (s == 1) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h5A5A_5A55_5A5A_5A5A;
         wr_q(7'd6, v, 64'd0);
         rd_chk("R9 status", 7'd6, (v & ~64'h0000_000F_0000_0000) | ST_RST, 1'b0);
      end

      // R10 out-of-range index
      for (int i = 64; i < 128; i++) begin
         rd_chk("R10 oor read", 7'(i), 64'd0, 1'b1);
      end
      do_wr(7'd77, 64'hDEAD_BEEF_DEAD_BEEF, 64'd0, f);
      check("R10 oor write fault", {63'd0, f}, 64'd1);
      do_wr(7'd73, 64'hDEAD_BEEF_DEAD_BEEF, 64'd0, f);
      check("R10 oor write fault", {63'd0, f}, 64'd1);
      rd_chk("R10 alias untouched", 7'd13, {32'hA5C3_000D, ~32'(13 * 7)}, 1'b0);
      rd_chk("R10 tsel untouched", 7'd9, 64'h8000_0000_0000_0000, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule